// File: doc/BRIEF.md
# Pipeline Hazard and Branch Flush Controller

This block steers a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, writeback). It keeps a small in-flight writer count for every architectural register; a register whose count is non-zero is stale. The block compares the decode-stage sources against that stale state and against the destination of the instruction now in execute. From this it chooses one of three actions for each decode cycle. It forwards the execute result when that result can be used. It holds the front of the pipe when the needed value is still travelling through memory or writeback. Otherwise it lets the instruction go.

Branches are resolved in execute. Fetch always guesses not-taken and runs ahead at the sequential address. When execute reports a wrong guess, the instruction in decode and the instruction in fetch are both turned into bubbles. The fetch address for the next cycle becomes the resolved target. A wrong guess wins over a hold in the same cycle. A squashed instruction never marks its destination stale.

The decode stage hands its instruction to execute through a valid/ready pair. `dec_valid` means decode holds an instruction. `dec_ready` low means that instruction must stay in decode, and fetch must stay where it is. When `dec_ready` is high, the decode content leaves this cycle: it issues if there is no flush, and it is discarded if there is one. The execute, memory and writeback information and the branch result are plain status inputs with no back-pressure.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A decode instruction that uses a stale source register, where execute cannot supply that register, is held. In that cycle `dec_ready`=0, `pc_sel`=1 (hold), `next_pc`=`fetch_pc` and `ex_bubble`=1.
- R2: A register's stale state ends at the clock edge where its last in-flight writer is reported on the writeback inputs. A held reader is released in the following cycle.
- R3: When a used source equals the destination of a valid execute-stage writer with `ex_res_ok`=1, the matching select (`fwd_a` or `fwd_b`) is 1 (execute result) and no hold occurs. Otherwise the select is 0 (register file).
- R4: A writer in execute with `ex_res_ok`=0 (a load) cannot be forwarded. A dependent instruction is held until that writer has passed writeback.
- R5: Register 0 is never stale and is never forwarded. This holds whether it is read or named as a destination.
- R6: When `br_resolve`=1 and `br_wrong`=1, the block drives `if_squash`=1, `ex_bubble`=1, `pc_sel`=2 (redirect) and `next_pc`=`br_target`.
- R7: A wrong-guess flush overrides a hold in the same cycle and forces `dec_ready`=1. The squashed decode instruction does not mark its destination stale.
- R8: Without a flush or a hold, `pc_sel`=0 (sequential) and `next_pc`=`fetch_pc`+4. A correctly guessed branch causes no flush.
- R9: A source whose use bit is 0 never causes a hold or a forward.
- R10: After reset no register is stale, so the first instruction proceeds whatever it reads.
- R11: With more than one writer to the same register in flight, the register stays stale until the youngest of them has passed writeback.
- R12: When `dec_valid`=0, `dec_ready`=1, `ex_bubble`=1, and no register changes state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_rs1 | input | 5 | Decode first source register |
| dec_rs1_use | input | 1 | First source is read |
| dec_rs2 | input | 5 | Decode second source register |
| dec_rs2_use | input | 1 | Second source is read |
| dec_rd | input | 5 | Decode destination register |
| dec_rd_we | input | 1 | Decode instruction writes its destination |
| dec_ready | output | 1 | Decode content leaves this cycle (issued or squashed) |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_rd | input | 5 | Execute destination register |
| ex_rd_we | input | 1 | Execute instruction writes its destination |
| ex_res_ok | input | 1 | Execute result is available for forwarding this cycle |
| br_resolve | input | 1 | A branch is resolving in execute |
| br_wrong | input | 1 | The not-taken guess was wrong |
| br_target | input | 32 | Correct fetch address after a wrong guess |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_rd | input | 5 | Writeback destination register |
| wb_rd_we | input | 1 | Writeback instruction writes its destination |
| fetch_pc | input | 32 | Address currently being fetched |
| fwd_a | output | 1 | First source select: 0 register file, 1 execute result |
| fwd_b | output | 1 | Second source select: 0 register file, 1 execute result |
| ex_bubble | output | 1 | Execute stage loads a bubble next cycle |
| if_squash | output | 1 | Decode stage loads a bubble next cycle |
| pc_sel | output | 2 | Next fetch source: 0 sequential, 1 hold, 2 redirect |
| next_pc | output | 32 | Next fetch address |

## Verification
The whole state of this block is the per-register writer count. Any error in it shows at the ports the first time decode reads the affected register. A lost increment gives a missing hold, which means a stale operand is consumed. An extra increment or a lost decrement gives a hold that never releases. Both appear in the same cycle as that read. The bench therefore runs dependency chains at distances of one, two and three instructions, loads, duplicate writers, register 0 and squashed writers. It compares every output on every cycle against a model built from stage contents, so a corrupted count shows up within one instruction of the first reader.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    PC_SEQ      = 2'd0,
    PC_HOLD     = 2'd1,
    PC_REDIRECT = 2'd2
  } pc_sel_e;

  typedef enum logic {
    FWD_RF = 1'b0,
    FWD_EX = 1'b1
  } fwd_sel_e;

  localparam int unsigned MAX_INFLIGHT = 3;

endpackage

// File: rtl/hz_stale_track.sv
module hz_stale_track #(
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG),
  parameter int CW   = $clog2(hz_pkg::MAX_INFLIGHT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [AW-1:0]   set_idx,
  input  logic            clr_en,
  input  logic [AW-1:0]   clr_idx,
  output logic [NREG-1:0] stale
);

  // One in-flight writer counter per register; register 0 has none.
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign stale[g] = 1'b0;
    end else begin : g_live
      logic [CW-1:0] cnt;
      logic          up;
      logic          dn;

      assign up = set_en && (set_idx == AW'(g));
      assign dn = clr_en && (clr_idx == AW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (up && !dn) begin
          cnt <= cnt + 1'b1;
        end else if (dn && !up) begin
          cnt <= cnt - 1'b1;
        end
      end

      assign stale[g] = |cnt;
    end
  end

endmodule

// File: rtl/hz_src_check.sv
module hz_src_check #(
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic            src_use,
  input  logic [AW-1:0]   src_idx,
  input  logic [NREG-1:0] stale,
  input  logic            ex_valid,
  input  logic [AW-1:0]   ex_rd,
  input  logic            ex_rd_we,
  input  logic            ex_res_ok,
  output logic            fwd,
  output logic            block
);

  logic live;
  logic pending;
  logic ex_hit;

  // Register 0 is excluded from both forwarding and hazard detection.
  assign live    = src_use && (src_idx != '0);
  assign pending = live && stale[src_idx];
  assign ex_hit  = ex_valid && ex_rd_we && ex_res_ok && (ex_rd == src_idx);

  assign fwd   = pending && ex_hit;
  assign block = pending && !ex_hit;

endmodule

// File: rtl/hz_redirect.sv
module hz_redirect #(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            flush,
  input  logic            stall,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic [XLEN-1:0] br_target,
  output logic [1:0]      pc_sel,
  output logic [XLEN-1:0] next_pc
);

  import hz_pkg::*;

  pc_sel_e sel;

  always_comb begin
    if (flush) begin
      sel     = PC_REDIRECT;
      next_pc = br_target;
    end else if (stall) begin
      sel     = PC_HOLD;
      next_pc = fetch_pc;
    end else begin
      sel     = PC_SEQ;
      next_pc = fetch_pc + XLEN'(PC_STEP);
    end
  end

  assign pc_sel = sel;

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int NREG    = 32,
  parameter int AW      = $clog2(NREG),
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic [AW-1:0]   dec_rs1,
  input  logic            dec_rs1_use,
  input  logic [AW-1:0]   dec_rs2,
  input  logic            dec_rs2_use,
  input  logic [AW-1:0]   dec_rd,
  input  logic            dec_rd_we,
  output logic            dec_ready,
  input  logic            ex_valid,
  input  logic [AW-1:0]   ex_rd,
  input  logic            ex_rd_we,
  input  logic            ex_res_ok,
  input  logic            br_resolve,
  input  logic            br_wrong,
  input  logic [XLEN-1:0] br_target,
  input  logic            wb_valid,
  input  logic [AW-1:0]   wb_rd,
  input  logic            wb_rd_we,
  input  logic [XLEN-1:0] fetch_pc,
  output logic            fwd_a,
  output logic            fwd_b,
  output logic            ex_bubble,
  output logic            if_squash,
  output logic [1:0]      pc_sel,
  output logic [XLEN-1:0] next_pc
);

  localparam int NSRC = 2;

  logic [NREG-1:0] stale;
  logic [AW-1:0]   src_idx [NSRC];
  logic [NSRC-1:0] src_use;
  logic [NSRC-1:0] src_fwd;
  logic [NSRC-1:0] src_block;
  logic            flush;
  logic            stall;
  logic            issue;

  assign src_idx[0] = dec_rs1;
  assign src_idx[1] = dec_rs2;
  assign src_use    = {dec_rs2_use, dec_rs1_use};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hz_src_check #(.NREG(NREG), .AW(AW)) u_src (
      .src_use   (dec_valid && src_use[s]),
      .src_idx   (src_idx[s]),
      .stale     (stale),
      .ex_valid  (ex_valid),
      .ex_rd     (ex_rd),
      .ex_rd_we  (ex_rd_we),
      .ex_res_ok (ex_res_ok),
      .fwd       (src_fwd[s]),
      .block     (src_block[s])
    );
  end

  assign flush = br_resolve && br_wrong;
  assign stall = dec_valid && (|src_block);
  assign issue = dec_valid && !stall && !flush;

  assign dec_ready = !stall || flush;
  assign ex_bubble = !issue;
  assign if_squash = flush;
  assign fwd_a     = src_fwd[0];
  assign fwd_b     = src_fwd[1];

  hz_stale_track #(.NREG(NREG), .AW(AW)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (issue && dec_rd_we),
    .set_idx (dec_rd),
    .clr_en  (wb_valid && wb_rd_we),
    .clr_idx (wb_rd),
    .stale   (stale)
  );

  hz_redirect #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_redir (
    .flush     (flush),
    .stall     (stall),
    .fetch_pc  (fetch_pc),
    .br_target (br_target),
    .pc_sel    (pc_sel),
    .next_pc   (next_pc)
  );

endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int AW      = 5,
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic [AW-1:0]   dec_rs1,
  input logic            dec_rs1_use,
  input logic [AW-1:0]   dec_rs2,
  input logic            dec_rs2_use,
  input logic            dec_ready,
  input logic            ex_valid,
  input logic [AW-1:0]   ex_rd,
  input logic            ex_rd_we,
  input logic            ex_res_ok,
  input logic            br_resolve,
  input logic            br_wrong,
  input logic [XLEN-1:0] br_target,
  input logic [XLEN-1:0] fetch_pc,
  input logic            fwd_a,
  input logic            fwd_b,
  input logic            ex_bubble,
  input logic            if_squash,
  input logic [1:0]      pc_sel,
  input logic [XLEN-1:0] next_pc
);

  import hz_pkg::*;

  // R1
  hold_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> (pc_sel == PC_HOLD && next_pc == fetch_pc && ex_bubble));

  // R3
  fwd_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a |-> (dec_valid && dec_rs1_use && ex_valid && ex_rd_we && ex_res_ok && ex_rd == dec_rs1));

  // R3
  fwd_b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_b |-> (dec_valid && dec_rs2_use && ex_valid && ex_rd_we && ex_res_ok && ex_rd == dec_rs2));

  // R5
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_rs1 == '0) |-> !fwd_a) and ((dec_rs2 == '0) |-> !fwd_b));

  // R6
  flush_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_resolve && br_wrong) |-> (if_squash && ex_bubble && dec_ready && pc_sel == PC_REDIRECT && next_pc == br_target));

  // R6
  squash_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_squash |-> (br_resolve && br_wrong));

  // R8
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(br_resolve && br_wrong) && dec_ready) |-> (pc_sel == PC_SEQ && next_pc == fetch_pc + XLEN'(PC_STEP)));

  // R12
  idle_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (dec_ready && ex_bubble && !fwd_a && !fwd_b));

endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.AW(AW), .XLEN(XLEN), .PC_STEP(PC_STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dec_valid   (dec_valid),
  .dec_rs1     (dec_rs1),
  .dec_rs1_use (dec_rs1_use),
  .dec_rs2     (dec_rs2),
  .dec_rs2_use (dec_rs2_use),
  .dec_ready   (dec_ready),
  .ex_valid    (ex_valid),
  .ex_rd       (ex_rd),
  .ex_rd_we    (ex_rd_we),
  .ex_res_ok   (ex_res_ok),
  .br_resolve  (br_resolve),
  .br_wrong    (br_wrong),
  .br_target   (br_target),
  .fetch_pc    (fetch_pc),
  .fwd_a       (fwd_a),
  .fwd_b       (fwd_b),
  .ex_bubble   (ex_bubble),
  .if_squash   (if_squash),
  .pc_sel      (pc_sel),
  .next_pc     (next_pc)
);

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;

  localparam int PMAX = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [4:0]  dec_rs1 = '0;
  logic        dec_rs1_use = 1'b0;
  logic [4:0]  dec_rs2 = '0;
  logic        dec_rs2_use = 1'b0;
  logic [4:0]  dec_rd = '0;
  logic        dec_rd_we = 1'b0;
  logic        dec_ready;
  logic        ex_valid = 1'b0;
  logic [4:0]  ex_rd = '0;
  logic        ex_rd_we = 1'b0;
  logic        ex_res_ok = 1'b0;
  logic        br_resolve = 1'b0;
  logic        br_wrong = 1'b0;
  logic [31:0] br_target = '0;
  logic        wb_valid = 1'b0;
  logic [4:0]  wb_rd = '0;
  logic        wb_rd_we = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        fwd_a;
  logic        fwd_b;
  logic        ex_bubble;
  logic        if_squash;
  logic [1:0]  pc_sel;
  logic [31:0] next_pc;

  always #4 clk = ~clk;

  pipe_hazard_ctrl u_pipe_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_rs1(dec_rs1), .dec_rs1_use(dec_rs1_use),
    .dec_rs2(dec_rs2), .dec_rs2_use(dec_rs2_use), .dec_rd(dec_rd), .dec_rd_we(dec_rd_we),
    .dec_ready(dec_ready),
    .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_rd_we(ex_rd_we), .ex_res_ok(ex_res_ok),
    .br_resolve(br_resolve), .br_wrong(br_wrong), .br_target(br_target),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_rd_we(wb_rd_we),
    .fetch_pc(fetch_pc),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .ex_bubble(ex_bubble), .if_squash(if_squash),
    .pc_sel(pc_sel), .next_pc(next_pc)
  );

  // Program held as parallel arrays; a slot holds a program index or -1.
  int    n_prog = 0;
  bit    p_v  [PMAX];
  int    p_rs1[PMAX];
  bit    p_u1 [PMAX];
  int    p_rs2[PMAX];
  bit    p_u2 [PMAX];
  int    p_rd [PMAX];
  bit    p_we [PMAX];
  bit    p_ld [PMAX];
  bit    p_br [PMAX];
  bit    p_bad[PMAX];
  int    p_tgt[PMAX];
  string p_tag[PMAX];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic put(input bit v, input int rs1, input bit u1, input int rs2, input bit u2,
                     input int rd, input bit we, input bit ld, input bit br, input bit bad,
                     input int tgt, input string tag);
    p_v[n_prog] = v;   p_rs1[n_prog] = rs1; p_u1[n_prog] = u1;
    p_rs2[n_prog] = rs2; p_u2[n_prog] = u2; p_rd[n_prog] = rd;
    p_we[n_prog] = we; p_ld[n_prog] = ld;   p_br[n_prog] = br;
    p_bad[n_prog] = bad; p_tgt[n_prog] = tgt; p_tag[n_prog] = tag;
    n_prog++;
  endtask

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference pipeline contents
  int s_dec = -1, s_ex = -1, s_mem = -1, s_wb = -1;
  int fi = 0;

  function automatic bit writes(input int slot, input int r);
    return slot >= 0 && p_we[slot] && p_rd[slot] == r && r != 0;
  endfunction

  function automatic bit is_stale(input int r);
    return writes(s_ex, r) || writes(s_mem, r) || writes(s_wb, r);
  endfunction

  function automatic bit ex_gives(input int r);
    return writes(s_ex, r) && !p_ld[s_ex];
  endfunction

  initial begin : main
    // R10: first instruction reads registers right after reset
    put(1, 1, 1, 2, 1, 1, 1, 0, 0, 0, 0, "R10");
    // R5: reads of register 0
    put(1, 0, 1, 0, 1, 1, 1, 0, 0, 0, 0, "R5");
    // R3: back-to-back chains forwarded from execute
    put(1, 1, 1, 1, 1, 2, 1, 0, 0, 0, 0, "R3");
    put(1, 2, 1, 0, 0, 3, 1, 0, 0, 0, 0, "R3");
    put(1, 3, 1, 0, 0, 4, 1, 1, 0, 0, 0, "R3");
    // R4: consumer of a load
    put(1, 4, 1, 0, 0, 5, 1, 0, 0, 0, 0, "R4");
    put(1, 0, 0, 5, 1, 6, 1, 0, 0, 0, 0, "R3");
    // R12: fetch bubble
    put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    // R1/R2: distance-two dependency held, then released
    put(1, 6, 1, 6, 1, 7, 1, 0, 0, 0, 0, "R1");
    put(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
    put(1, 0, 1, 7, 1, 8, 1, 0, 0, 0, 0, "R2");
    // R9: unused sources
    put(1, 0, 0, 0, 0, 10, 1, 0, 0, 0, 0, "R9");
    put(1, 10, 0, 10, 0, 11, 1, 0, 0, 0, 0, "R9");
    // R11: two writers of one register
    put(1, 0, 0, 0, 0, 3, 1, 0, 0, 0, 0, "R11");
    put(1, 0, 0, 0, 0, 3, 1, 0, 0, 0, 0, "R11");
    put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    put(1, 3, 1, 0, 0, 12, 1, 0, 0, 0, 0, "R11");
    // R6/R7: wrong guess while decode is held
    put(1, 0, 0, 0, 0, 5, 1, 1, 0, 0, 0, "R7");
    put(1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 22, "R6");
    put(1, 5, 1, 0, 0, 13, 1, 0, 0, 0, 0, "R7");
    put(1, 0, 0, 0, 0, 14, 1, 0, 0, 0, 0, "R7");
    put(1, 0, 0, 0, 0, 15, 1, 0, 0, 0, 0, "R7");
    // 22: target; squashed writers must not be stale
    put(1, 13, 1, 14, 1, 16, 1, 0, 0, 0, 0, "R7");
    // R8: correctly guessed branch
    put(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
    put(1, 0, 0, 0, 0, 17, 1, 0, 0, 0, 0, "R8");

    repeat (3) @(negedge clk);
    check("R10", "dec_ready in reset", longint'(dec_ready), 1);
    check("R10", "pc_sel in reset", longint'(pc_sel), 0);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 120; cyc++) begin
      bit    dv, flush, fa, fb, ba, bb, stall, issue;
      int    a_src, b_src;
      string tg;
      @(negedge clk);
      dv = (s_dec >= 0);
      dec_valid   = dv;
      dec_rs1     = dv ? 5'(p_rs1[s_dec]) : 5'd0;
      dec_rs1_use = dv ? p_u1[s_dec] : 1'b0;
      dec_rs2     = dv ? 5'(p_rs2[s_dec]) : 5'd0;
      dec_rs2_use = dv ? p_u2[s_dec] : 1'b0;
      dec_rd      = dv ? 5'(p_rd[s_dec]) : 5'd0;
      dec_rd_we   = dv ? p_we[s_dec] : 1'b0;
      ex_valid    = (s_ex >= 0);
      ex_rd       = (s_ex >= 0) ? 5'(p_rd[s_ex]) : 5'd0;
      ex_rd_we    = (s_ex >= 0) ? p_we[s_ex] : 1'b0;
      ex_res_ok   = (s_ex >= 0) ? !p_ld[s_ex] : 1'b0;
      br_resolve  = (s_ex >= 0) ? p_br[s_ex] : 1'b0;
      br_wrong    = (s_ex >= 0) ? (p_br[s_ex] && p_bad[s_ex]) : 1'b0;
      br_target   = (s_ex >= 0) ? 32'(p_tgt[s_ex] * 4) : 32'd0;
      wb_valid    = (s_wb >= 0);
      wb_rd       = (s_wb >= 0) ? 5'(p_rd[s_wb]) : 5'd0;
      wb_rd_we    = (s_wb >= 0) ? p_we[s_wb] : 1'b0;
      fetch_pc    = 32'(fi * 4);
      #1;
      flush = br_wrong;
      a_src = dv ? p_rs1[s_dec] : 0;
      b_src = dv ? p_rs2[s_dec] : 0;
      fa = dv && p_u1[s_dec] && a_src != 0 && ex_gives(a_src);
      fb = dv && p_u2[s_dec] && b_src != 0 && ex_gives(b_src);
      ba = dv && p_u1[s_dec] && a_src != 0 && is_stale(a_src) && !ex_gives(a_src);
      bb = dv && p_u2[s_dec] && b_src != 0 && is_stale(b_src) && !ex_gives(b_src);
      stall = ba || bb;
      issue = dv && !stall && !flush;
      tg = dv ? p_tag[s_dec] : "R12";

      check(tg, "dec_ready", longint'(dec_ready), longint'(!stall || flush));
      check(tg, "fwd_a", longint'(fwd_a), longint'(fa));
      check(tg, "fwd_b", longint'(fwd_b), longint'(fb));
      check(flush ? "R7" : tg, "ex_bubble", longint'(ex_bubble), longint'(!issue));
      check("R6", "if_squash", longint'(if_squash), longint'(flush));
      check(flush ? "R6" : (stall ? "R1" : "R8"), "pc_sel", longint'(pc_sel),
            flush ? 2 : (stall ? 1 : 0));
      check(flush ? "R6" : (stall ? "R1" : "R8"), "next_pc", longint'(next_pc),
            flush ? longint'(br_target) : (stall ? longint'(fi * 4) : longint'(fi * 4 + 4)));

      // advance the reference pipeline
      s_wb  = s_mem;
      s_mem = s_ex;
      s_ex  = issue ? s_dec : -1;
      if (flush) begin
        s_dec = -1;
        fi    = p_tgt[s_mem];
      end else if (!stall) begin
        s_dec = (fi < n_prog && p_v[fi]) ? fi : -1;
        fi++;
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule